// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This controller decides when a secondary power rail may be switched on. It watches four digital flags. Two are undervoltage-lockout indications, one for each supply. The third reports that the primary rail is good. The fourth is an enable, which can also serve as a second rail-good indication. Each flag arrives asynchronously and is resynchronised to the clock before use.

Once every condition holds, the controller counts a turn-on delay and then raises a gate-enable that drives an external switch. If any condition fails, the gate-enable drops without waiting for a delay. A failure during the count clears the count, so the next valid period starts over from zero. While the delay runs, a status flag and the elapsed count are reported.

Two variants exist, chosen by a parameter:
- **Fixed variant:** the delay is 300 ms, derived from the clock frequency.
- **Programmable variant:** the enable input is ignored and the delay is taken from a configuration input.

For more than two rails, stages are chained: the gate-enable of one stage becomes the primary rail-good input of the next.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While `rst` is high (synchronous, active high), the block holds `gate_on` = 0, `counting` = 0 and `elapsed` = 0 from the next clock edge on.
- R2: `gate_on` and `counting` stay 0 while both `sup_a_low` and `sup_b_low` are 1, whatever the other inputs do. Either supply flag at 0 is enough to permit operation, so swapping which supply is low does not drop an active output.
- R3: Counting starts only when `prim_good` and `en_good` are both 1 (and R2 permits). `counting` rises on the 3rd rising clock edge after the last condition becomes valid: two synchroniser stages plus the state register.
- R4: In the fixed variant the delay is LIMIT = (CLK_HZ/1000)*DELAY_MS cycles, with DELAY_MS defaulting to 300. `gate_on` rises on rising edge LIMIT+3 after all conditions become valid, and `counting` falls on that same edge.
- R5: When any condition becomes invalid, `gate_on` falls on the 3rd rising edge after the change, with no delay count.
- R6: If a condition fails while counting, `counting` falls and `elapsed` returns to 0 on the 3rd edge. When conditions recover, the full delay is counted again from 0.
- R7: In the programmable variant (PROG_DELAY = 1), `en_good` is ignored and treated as 1. LIMIT is `delay_cfg`, except that a value of 0 is treated as 1, so `gate_on` rises on edge `delay_cfg`+3.
- R8: `counting` is 1 only while the delay runs. `counting` and `gate_on` are never both 1. `elapsed` is 0 on entry to counting, rises by one per cycle while counting, and is 0 whenever `counting` is 0.
- R9: Stages chain. When one stage's `gate_on` drives the next stage's `prim_good`, the next stage starts counting on the 3rd edge after the first stage's `gate_on` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_a_low | input | 1 | Supply A in undervoltage lockout (async) |
| sup_b_low | input | 1 | Supply B in undervoltage lockout (async) |
| prim_good | input | 1 | Primary rail above its threshold (async) |
| en_good | input | 1 | Enable or second rail-good (async); ignored in programmable variant |
| delay_cfg | input | CNT_W | Delay in cycles for the programmable variant; ignored in the fixed variant |
| gate_on | output | 1 | Gate-enable for the secondary rail switch |
| counting | output | 1 | High while the turn-on delay runs |
| elapsed | output | CNT_W | Cycles counted so far in the current delay |

## Verification
Every result arrives at a fixed cycle count after a stimulus:
- `counting` rises and falls three edges after an input change.
- `gate_on` falls three edges after a condition is lost.
- `gate_on` rises LIMIT+3 edges after the conditions become valid.
- In a chain, the next stage counts from the edge at which the upstream gate rises.

The driver changes inputs on a falling edge and queues each expected value tagged with the exact cycle at which it is due. The monitor samples shortly after each falling edge and compares only the items due in that cycle. The cycle just before each due edge is also checked, so an early output is caught as well as a late one.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    // Controller states
    typedef enum logic [1:0] {
        SEQ_OFF      = 2'd0,
        SEQ_COUNTING = 2'd1,
        SEQ_ON       = 2'd2
    } seq_state_e;

    // Synchroniser depth and flag bundle
    localparam int SYNC_STAGES = 2;
    localparam int NUM_FLAGS   = 4;

    typedef struct packed {
        logic sup_a_low;
        logic sup_b_low;
        logic prim_good;
        logic en_good;
    } flag_vec_t;

    // Whole milliseconds converted to clock cycles
    function automatic int cycles_for_ms(input int clk_hz, input int ms);
        return (clk_hz / 1000) * ms;
    endfunction

    // All turn-on conditions: one supply out of lockout, primary good, enable
    function automatic logic conditions_met(input flag_vec_t f, input logic use_en);
        return (!f.sup_a_low || !f.sup_b_low) && f.prim_good && (f.en_good || !use_en);
    endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end

        assign sync_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             at_end
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (advance) begin
            count <= count + ONE;
        end
    end

    // Last cycle of the delay window
    assign at_end = (count == (limit - ONE));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import rail_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cond_ok,
    input  logic       at_end,
    output seq_state_e state,
    output logic       tmr_clear,
    output logic       tmr_advance
);

    seq_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_OFF:      if (cond_ok) nxt = SEQ_COUNTING;
            SEQ_COUNTING: if (!cond_ok) nxt = SEQ_OFF;
                          else if (at_end) nxt = SEQ_ON;
            SEQ_ON:       if (!cond_ok) nxt = SEQ_OFF;
            default:      nxt = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Timer runs only inside a valid count; everything else clears it
    assign tmr_advance = (state == SEQ_COUNTING) && cond_ok && !at_end;
    assign tmr_clear   = !tmr_advance;

endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
    import rail_seq_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int DELAY_MS   = 300,
    parameter bit PROG_DELAY = 1'b0,
    parameter int CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sup_a_low,
    input  logic             sup_b_low,
    input  logic             prim_good,
    input  logic             en_good,
    input  logic [CNT_W-1:0] delay_cfg,
    output logic             gate_on,
    output logic             counting,
    output logic [CNT_W-1:0] elapsed
);

    localparam int               FIXED_CYCLES = cycles_for_ms(CLK_HZ, DELAY_MS);
    localparam logic [CNT_W-1:0] FIXED_LIMIT  = CNT_W'(FIXED_CYCLES);

    flag_vec_t        raw_flags;
    flag_vec_t        syn_flags;
    logic             cond_ok;
    logic [CNT_W-1:0] lim_eff;
    logic             at_end;
    logic             tmr_clear;
    logic             tmr_advance;
    seq_state_e       state;

    assign raw_flags = '{sup_a_low: sup_a_low, sup_b_low: sup_b_low,
                         prim_good: prim_good, en_good: en_good};

    flag_sync #(
        .WIDTH (NUM_FLAGS),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_in(raw_flags),
        .sync_out(syn_flags)
    );

    // Variant choice: delay source and whether enable takes part
    if (PROG_DELAY) begin : g_prog
        assign lim_eff = (delay_cfg == '0) ? CNT_W'(1) : delay_cfg;
        assign cond_ok = conditions_met(syn_flags, 1'b0);
    end else begin : g_fixed
        assign lim_eff = FIXED_LIMIT;
        assign cond_ok = conditions_met(syn_flags, 1'b1);
    end

    seq_timer #(
        .CNT_W(CNT_W)
    ) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (tmr_clear),
        .advance(tmr_advance),
        .limit  (lim_eff),
        .count  (elapsed),
        .at_end (at_end)
    );

    seq_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .cond_ok    (cond_ok),
        .at_end     (at_end),
        .state      (state),
        .tmr_clear  (tmr_clear),
        .tmr_advance(tmr_advance)
    );

    assign gate_on  = (state == SEQ_ON);
    assign counting = (state == SEQ_COUNTING);

endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ok_s,
    input logic             gate_on,
    input logic             counting,
    input logic [CNT_W-1:0] elapsed,
    input logic [CNT_W-1:0] limit
);

    // R5 R2: a lost condition leaves neither count nor gate one cycle later
    assert_drop_off_R5: assert property (@(posedge clk) disable iff (rst)
        !ok_s |=> (!gate_on && !counting));

    // R8: gate and count never together
    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gate_on, counting}));

    // R6: every count starts from zero
    assert_start_zero_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(counting) |-> (elapsed == '0));

    // R8: steady count advances by one per cycle
    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (counting && ok_s && (elapsed != limit - CNT_W'(1)))
        |=> (counting && (elapsed == $past(elapsed) + CNT_W'(1))));

    // R4 R7: gate rises only out of a completed count
    assert_turn_on_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_on) |-> ($past(counting) && ($past(elapsed) == $past(limit) - CNT_W'(1))));

    // R8: idle timer reads zero
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !counting |-> (elapsed == '0));

endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .ok_s    (cond_ok),
    .gate_on (gate_on),
    .counting(counting),
    .elapsed (elapsed),
    .limit   (lim_eff)
);

// File: tb/rail_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rail_seq_ctrl_tb_top;

    localparam int CNT_W  = 16;
    localparam int CLK_HZ = 10_000;
    localparam int LIMIT  = (CLK_HZ / 1000) * 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // Fixed-variant stimulus
    logic fa = 1'b1, fb = 1'b1, fp = 1'b0, fe = 1'b0;
    // Programmable-variant stimulus
    logic pa = 1'b1, pb = 1'b1, pp_drv = 1'b0, pe = 1'b0, casc = 1'b0;
    logic [CNT_W-1:0] cfg = '0;

    logic             f_gate, f_cnt, p_gate, p_cnt;
    logic [CNT_W-1:0] f_el, p_el;
    logic             pp;
    assign pp = casc ? f_gate : pp_drv;

    rail_seq_ctrl #(.CLK_HZ(CLK_HZ), .DELAY_MS(300), .PROG_DELAY(1'b0), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .sup_a_low(fa), .sup_b_low(fb), .prim_good(fp),
        .en_good(fe), .delay_cfg(cfg), .gate_on(f_gate), .counting(f_cnt), .elapsed(f_el));

    rail_seq_ctrl #(.CLK_HZ(CLK_HZ), .DELAY_MS(300), .PROG_DELAY(1'b1), .CNT_W(CNT_W)) dut_p (
        .clk(clk), .rst(rst), .sup_a_low(pa), .sup_b_low(pb), .prim_good(pp),
        .en_good(pe), .delay_cfg(cfg), .gate_on(p_gate), .counting(p_cnt), .elapsed(p_el));

    typedef struct {
        int    cyc;
        bit    prog;
        int    kind;   // 0 gate, 1 counting, 2 elapsed
        int    val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int off, input bit prog, input int kind,
                             input int val, input string tag);
        exp_t e;
        e.cyc = cyc + off; e.prog = prog; e.kind = kind; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare items due this cycle, away from the clock edge
    always @(negedge clk) begin
        #1;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                int act;
                case (q[i].kind)
                    0:       act = q[i].prog ? int'(p_gate) : int'(f_gate);
                    1:       act = q[i].prog ? int'(p_cnt)  : int'(f_cnt);
                    default: act = q[i].prog ? int'(p_el)   : int'(f_el);
                endcase
                n_cmp++;
                if (act != q[i].val) begin
                    n_bad++;
                    $display("FAIL %s cyc=%0d prog=%0d kind=%0d actual=%0d expected=%0d",
                             q[i].tag, cyc, q[i].prog, q[i].kind, act, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        // R1 reset state
        for (int k = 0; k < 2; k++) begin
            expect_at(0, k[0], 0, 0, "R1");
            expect_at(0, k[0], 1, 0, "R1");
            expect_at(0, k[0], 2, 0, "R1");
        end
        tick(1);
        rst = 1'b0;
        tick(5);

        // R2: both supplies in lockout hold everything off
        fp = 1'b1; fe = 1'b1;
        expect_at(5, 0, 1, 0, "R2");
        expect_at(20, 0, 0, 0, "R2");
        tick(25);

        // R3 R4 R8: supply A leaves lockout, full fixed delay
        fa = 1'b0;
        expect_at(2, 0, 1, 0, "R3");
        expect_at(3, 0, 1, 1, "R3");
        expect_at(3, 0, 2, 0, "R8");
        expect_at(8, 0, 2, 5, "R8");
        expect_at(LIMIT + 2, 0, 0, 0, "R4");
        expect_at(LIMIT + 3, 0, 0, 1, "R4");
        expect_at(LIMIT + 3, 0, 1, 0, "R8");
        tick(LIMIT + 10);

        // R5: enable drop turns gate off at once; R3: primary alone not enough
        fe = 1'b0;
        expect_at(2, 0, 0, 1, "R5");
        expect_at(3, 0, 0, 0, "R5");
        expect_at(10, 0, 1, 0, "R3");
        tick(15);

        // R6: loss during count clears timer, then restart from zero
        fe = 1'b1;
        expect_at(3, 0, 1, 1, "R6");
        tick(103);
        fp = 1'b0;
        expect_at(3, 0, 1, 0, "R6");
        expect_at(3, 0, 2, 0, "R6");
        expect_at(3, 0, 0, 0, "R6");
        tick(10);
        fp = 1'b1;
        expect_at(3, 0, 1, 1, "R6");
        expect_at(3, 0, 2, 0, "R6");
        expect_at(103, 0, 2, 100, "R6");
        expect_at(LIMIT + 2, 0, 0, 0, "R6");
        expect_at(LIMIT + 3, 0, 0, 1, "R6");
        tick(LIMIT + 10);

        // R2: either supply suffices; both low forces off
        fa = 1'b1; fb = 1'b0;
        expect_at(10, 0, 0, 1, "R2");
        tick(12);
        fb = 1'b1;
        expect_at(3, 0, 0, 0, "R2");
        tick(8);

        // R7: programmable delay, enable ignored
        pa = 1'b0; pp_drv = 1'b1; pe = 1'b0; cfg = 16'd40;
        expect_at(3, 1, 1, 1, "R7");
        expect_at(42, 1, 0, 0, "R7");
        expect_at(43, 1, 0, 1, "R7");
        tick(50);
        pp_drv = 1'b0;
        tick(6);
        cfg = '0; pp_drv = 1'b1;
        expect_at(3, 1, 1, 1, "R7");
        expect_at(3, 1, 0, 0, "R7");
        expect_at(4, 1, 0, 1, "R7");
        tick(10);
        pp_drv = 1'b0;
        tick(6);

        // R9: fixed stage gate feeds programmable stage primary input
        fa = 1'b0; casc = 1'b1; cfg = 16'd10;
        expect_at(LIMIT + 3, 0, 0, 1, "R4");
        expect_at(LIMIT + 5, 1, 1, 0, "R9");
        expect_at(LIMIT + 6, 1, 1, 1, "R9");
        expect_at(LIMIT + 15, 1, 0, 0, "R9");
        expect_at(LIMIT + 16, 1, 0, 1, "R9");
        tick(LIMIT + 25);

        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL pending expectations actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule